// File: doc/BRIEF.md
# Port Disconnect Decision Timer

This block decides, for each of several powered ports, when power should be withdrawn because the attached load appears to have gone away. Two sensing methods are supported, each with its own enable bit. The DC method watches a flag that says the port's load current is below its minimum. The AC method watches a flag that says the measured AC detect current is below its own minimum. A method votes to disconnect only when its flag has persisted for longer than that method's timeout.

Each enabled method that is still satisfied keeps the port alive, so with both enabled a port stays powered as long as either one sees a load. A port with no method enabled is never switched off by this block. When the combined decision becomes true, the block emits a single-cycle turn-off request for that port. The power switch controller that receives the request is outside this block, as are the current comparators that produce the flags.

Top module: `disc_decider`

## Requirements
- R1: Bit p of `dis_en` (p = 0..NPORTS-1) enables the DC method for port p; bit NPORTS+p enables the AC method for port p. A flag of one method has no effect while only the other method's bit is set.
- R2: With only DC enabled on a powered port, if `dc_low[p]` is sampled high on DC_TIMEOUT+1 consecutive rising edges, `off_req[p]` is high during the cycle that follows the next rising edge.
- R3: With only AC enabled on a powered port, if `ac_low[p]` is sampled high on AC_TIMEOUT+1 consecutive rising edges, `off_req[p]` is high during the cycle that follows the next rising edge.
- R4: With both methods enabled, no request is issued while either method's persistence is incomplete; the request follows one edge after the later of the two completes.
- R5: A port with both enable bits clear never raises `off_req`, whatever its flags.
- R6: A request lasts exactly one cycle; no further request is issued while the disconnect condition continues unbroken.
- R7: A method's persistence count restarts when its flag is sampled low, when the port is off, or when the method is disabled; after a restart the full persistence is needed again.
- R8: While `rst_n` is low and in the cycle after it rises, `off_req` is all zero.
- R9: Ports are independent: the flags and enables of one port never cause a request on another.
- R10: No request is issued for a port whose `port_on` bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_on | input | NPORTS | Port currently powered |
| dc_low | input | NPORTS | Load current below DC minimum |
| ac_low | input | NPORTS | AC detect current below AC minimum |
| dis_en | input | 2*NPORTS | Method enables: DC in low half, AC in high half |
| off_req | output | NPORTS | One-cycle turn-off request per port |

## Verification
The assertions assume the flags, enables and port state are synchronous to `clk` and held at defined values from time zero, so that every past value sampled after reset is known. They also assume nothing outside the block clears a pending decision except the listed restart conditions. The stimulus changes every input only on the falling edge, starts all inputs at zero under reset, and returns each port to an idle state between scenarios so each persistence window begins from a cleared count.

// File: rtl/disc_pkg.sv
package disc_pkg;

    typedef struct packed {
        logic dc;
        logic ac;
    } meth_bits_t;

    function automatic logic keeps_alive(input logic en, input logic expired);
        return en && !expired;
    endfunction

endpackage

// File: rtl/persist_timer.sv
module persist_timer #(
    parameter int TIMEOUT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int LIMIT = TIMEOUT + 1;
    localparam int W     = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != W'(LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = (st_q.cnt == W'(LIMIT));

    p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));

    p_counts_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expired) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    p_holds_expired_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && expired) |=> expired);

endmodule

// File: rtl/disc_lane.sv
module disc_lane
    import disc_pkg::*;
#(
    parameter int DC_TIMEOUT = 6,
    parameter int AC_TIMEOUT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_on,
    input  logic dc_low,
    input  logic ac_low,
    input  logic dc_en,
    input  logic ac_en,
    output logic off_req
);
    typedef struct packed {
        logic trip_seen;
        logic pulse;
    } st_t;

    st_t        st_d, st_q;
    meth_bits_t run;
    meth_bits_t exp_now;
    logic       trip;

    assign run.dc = port_on && dc_en && dc_low;
    assign run.ac = port_on && ac_en && ac_low;

    persist_timer #(.TIMEOUT(DC_TIMEOUT)) u_dc_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run.dc),
        .expired (exp_now.dc)
    );

    persist_timer #(.TIMEOUT(AC_TIMEOUT)) u_ac_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run.ac),
        .expired (exp_now.ac)
    );

    always_comb begin
        st_d = st_q;
        trip = port_on && (dc_en || ac_en)
            && !keeps_alive(dc_en, exp_now.dc)
            && !keeps_alive(ac_en, exp_now.ac);
        st_d.trip_seen = trip;
        st_d.pulse     = trip && !st_q.trip_seen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_req = st_q.pulse;

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |=> !off_req);

    p_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past(dc_en || ac_en));

    p_needs_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past(port_on));

    p_all_enabled_expired_r4: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past((!dc_en || exp_now.dc) && (!ac_en || exp_now.ac)));

endmodule

// File: rtl/disc_decider.sv
module disc_decider #(
    parameter int NPORTS     = 4,
    parameter int DC_TIMEOUT = 6,
    parameter int AC_TIMEOUT = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORTS-1:0]     port_on,
    input  logic [NPORTS-1:0]     dc_low,
    input  logic [NPORTS-1:0]     ac_low,
    input  logic [2*NPORTS-1:0]   dis_en,
    output logic [NPORTS-1:0]     off_req
);
    localparam int AC_BASE = NPORTS;

    for (genvar p = 0; p < NPORTS; p++) begin : g_lane
        disc_lane #(
            .DC_TIMEOUT (DC_TIMEOUT),
            .AC_TIMEOUT (AC_TIMEOUT)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .port_on (port_on[p]),
            .dc_low  (dc_low[p]),
            .ac_low  (ac_low[p]),
            .dc_en   (dis_en[p]),
            .ac_en   (dis_en[AC_BASE+p]),
            .off_req (off_req[p])
        );
    end

    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |=> (off_req == '0));

    p_only_powered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((off_req & ~$past(port_on)) == '0));

endmodule

// File: tb/disc_decider_bench.sv
module disc_decider_bench;
    localparam int NP   = 4;
    localparam int DC_T = 6;
    localparam int AC_T = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] port_on = '0;
    logic [NP-1:0] dc_low = '0;
    logic [NP-1:0] ac_low = '0;
    logic [2*NP-1:0] dis_en = '0;
    logic [NP-1:0] off_req;

    int checks = 0;
    int errors = 0;
    int first_at [NP];
    int hits     [NP];

    always #10 clk = ~clk;

    disc_decider #(.NPORTS(NP), .DC_TIMEOUT(DC_T), .AC_TIMEOUT(AC_T)) u_disc_decider (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_on (port_on),
        .dc_low  (dc_low),
        .ac_low  (ac_low),
        .dis_en  (dis_en),
        .off_req (off_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic watch(input int n);
        for (int p = 0; p < NP; p++) begin
            first_at[p] = 0;
            hits[p]     = 0;
        end
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                if (off_req[p]) begin
                    hits[p]++;
                    if (first_at[p] == 0) first_at[p] = i;
                end
            end
        end
    endtask

    task automatic idle();
        dc_low = '0; ac_low = '0; dis_en = '0; port_on = '1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(off_req == '0, "R8 during reset", int'(off_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(off_req == '0, "R8 after reset", int'(off_req), 0);
    endtask

    task automatic t_dc_only(input int p);
        idle();
        dis_en[p] = 1'b1;
        dc_low[p] = 1'b1;
        watch(30);
        check(first_at[p] == DC_T + 2, "R2 dc timing", first_at[p], DC_T + 2);
        check(hits[p] == 1, "R6 dc single pulse", hits[p], 1);
    endtask

    task automatic t_ac_only(input int p);
        idle();
        dis_en[NP+p] = 1'b1;
        ac_low[p] = 1'b1;
        watch(40);
        check(first_at[p] == AC_T + 2, "R3 ac timing", first_at[p], AC_T + 2);
        check(hits[p] == 1, "R6 ac single pulse", hits[p], 1);
    endtask

    task automatic t_mapping();
        idle();
        dis_en[NP+1] = 1'b1;
        dc_low[1] = 1'b1;
        watch(30);
        check(hits[1] == 0, "R1 dc flag ignored under ac enable", hits[1], 0);
        idle();
        dis_en[1] = 1'b1;
        ac_low[1] = 1'b1;
        watch(30);
        check(hits[1] == 0, "R1 ac flag ignored under dc enable", hits[1], 0);
    endtask

    task automatic t_restart();
        idle();
        dis_en[0] = 1'b1;
        dc_low[0] = 1'b1;
        watch(DC_T);
        dc_low[0] = 1'b0;
        watch(1);
        check(hits[0] == 0, "R7 short hold no pulse", hits[0], 0);
        dc_low[0] = 1'b1;
        watch(30);
        check(first_at[0] == DC_T + 2, "R7 full window after drop", first_at[0], DC_T + 2);
        idle();
        dis_en[0] = 1'b1;
        dc_low[0] = 1'b1;
        watch(DC_T);
        dis_en[0] = 1'b0;
        watch(1);
        dis_en[0] = 1'b1;
        watch(30);
        check(first_at[0] == DC_T + 2, "R7 full window after disable", first_at[0], DC_T + 2);
    endtask

    task automatic t_both();
        idle();
        dis_en[2] = 1'b1;
        dis_en[NP+2] = 1'b1;
        dc_low[2] = 1'b1;
        watch(40);
        check(hits[2] == 0, "R4 ac keeps port alive", hits[2], 0);
        ac_low[2] = 1'b1;
        watch(40);
        check(first_at[2] == AC_T + 2, "R4 pulse after later method", first_at[2], AC_T + 2);
        check(hits[2] == 1, "R6 both single pulse", hits[2], 1);
    endtask

    task automatic t_neither();
        idle();
        dc_low = '1;
        ac_low = '1;
        watch(40);
        check(hits[3] == 0 && hits[0] == 0, "R5 no method no pulse", hits[3] + hits[0], 0);
    endtask

    task automatic t_port_off();
        idle();
        port_on[3] = 1'b0;
        dis_en[3] = 1'b1;
        dc_low[3] = 1'b1;
        watch(40);
        check(hits[3] == 0, "R10 off port no pulse", hits[3], 0);
        port_on[3] = 1'b1;
        watch(30);
        check(first_at[3] == DC_T + 2, "R7 count starts at power on", first_at[3], DC_T + 2);
    endtask

    task automatic t_indep();
        idle();
        dis_en[0] = 1'b1;
        dc_low[0] = 1'b1;
        dis_en[NP+2] = 1'b1;
        ac_low[2] = 1'b1;
        watch(40);
        check(first_at[0] == DC_T + 2, "R9 port0 dc", first_at[0], DC_T + 2);
        check(first_at[2] == AC_T + 2, "R9 port2 ac", first_at[2], AC_T + 2);
        check(hits[1] == 0 && hits[3] == 0, "R9 other ports quiet", hits[1] + hits[3], 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_dc_only(0);
        t_dc_only(3);
        t_ac_only(1);
        t_mapping();
        t_restart();
        t_both();
        t_neither();
        t_port_off();
        t_indep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule